// File: doc/BRIEF.md
# Flash Write Sequencer Status Flags

This block holds the status byte of a data-flash write command sequencer. It watches the sequencer enable, the sequencer idle/busy state and its two-bit state code, CPU strobes into the flash window, and the word being programmed together with the word already stored. It also takes single-cycle error, timeout and done pulses from the write engine. From these it keeps sticky flags for prohibited CPU access, write cut short by disabling, write error, timeout and finished, and raises an error interrupt request.

Software reads the byte through a bus register port. Each sticky flag is cleared by writing 0 to its bit, and writing 1 leaves it alone. A read that belongs to a read-modify-write cycle sees 1 on every sticky flag bit, so the write-back cannot clear flags by accident. A synchronous software reset clears all sticky flags. The sticky flags are only set while the sequencer is enabled. A clear write-incomplete flag does not by itself mean the write succeeded; software looks at the finished flag for that.

Top module: `fws_status`

## Requirements
- R1: While reset is active, and after it, before any event, `reg_rdata` is 0 (with idle and state inputs low) and `err_irq` is 0.
- R2: The prohibited-access flag (bit 7) sets when `cpu_acc` is high while `seq_en` is 1 and `seq_idle` is 0. A strobe while idle does not set it.
- R3: The write-incomplete flag (bit 6) sets on the cycle `seq_en` goes from 1 to 0 while `seq_idle` is 0. Disabling while idle leaves it clear.
- R4: The write-error flag (bit 5) sets on `wr_req` with `wr_prot` high (protected or erase-suspended sector).
- R5: The write-error flag sets on `wr_req` when some bit of `wr_data` is 1 where the same bit of `wr_old` is 0. A write that only turns 1s into 0s does not set it.
- R6: `eng_err` sets the write-error flag, `eng_tmo` sets the timeout flag (bit 4) and `eng_done` sets the finished flag (bit 3), each one cycle after the pulse.
- R7: With `seq_en` at 0, no event sets any flag, except the write-incomplete flag in the disabling cycle of R3.
- R8: `reg_wr` with a 0 in bit 7..3 of `reg_wdata` clears that flag, and a 1 leaves it unchanged. Bits 2..0 of the write are ignored. A set event in the same cycle wins over the clear.
- R9: `soft_rst` clears all sticky flags on the next edge and overrides any set event in the same cycle.
- R10: While `reg_rmw` is 1, `reg_rdata[7:3]` reads all ones. Bits 2..0 still show live idle and state.
- R11: `err_irq` is high exactly when `err_irq_en` is 1 and at least one of write-incomplete, write-error or timeout is set. The prohibited-access and finished flags never raise it.
- R12: The byte layout is bit 7 prohibited access, 6 write incomplete, 5 write error, 4 timeout, 3 finished, 2 `seq_idle`, 1..0 `seq_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seq_en | input | 1 | Sequencer enable |
| seq_idle | input | 1 | Sequencer is in its idle state |
| seq_state | input | STW | Sequencer state code, shown in the low bits |
| cpu_acc | input | 1 | CPU read or write strobe into the flash window |
| wr_req | input | 1 | Sequencer write attempt, one cycle |
| wr_prot | input | 1 | Target sector is protected or erase-suspended |
| wr_data | input | DW | Word to be programmed |
| wr_old | input | DW | Word currently stored at the target |
| eng_err | input | 1 | Write engine error pulse |
| eng_tmo | input | 1 | Write engine timeout pulse |
| eng_done | input | 1 | Write engine done pulse |
| reg_wr | input | 1 | Status byte write strobe |
| reg_wdata | input | 8 | Status byte write data |
| reg_rmw | input | 1 | Current read is part of a read-modify-write |
| soft_rst | input | 1 | Synchronous software reset of the flags |
| err_irq_en | input | 1 | Error interrupt enable |
| reg_rdata | output | 8 | Status byte read data |
| err_irq | output | 1 | Error interrupt request |

## Verification
Each flag is a single stored bit that shows up directly in `reg_rdata` one cycle after the event that sets or clears it. So a wrong flag state is visible in the next read unless `reg_rmw` masks it. A wrong set or clear priority shows in the cycle right after a same-cycle collision. A missed disable edge or a missed illegal-bit check leaves bit 6 or 5 low in the next cycle. Through `err_irq`, it also leaves the interrupt low in that same cycle.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int NFLAG = 5;
  localparam int STW   = 2;
  localparam int RW    = NFLAG + 1 + STW;

  // Index of each sticky flag inside the flag vector; the vector occupies
  // the top NFLAG bits of the status byte in this order.
  typedef enum logic [2:0] {
    F_FIN = 3'd0,
    F_TMO = 3'd1,
    F_WER = 3'd2,
    F_WIN = 3'd3,
    F_PAC = 3'd4
  } flag_e;

  localparam logic [NFLAG-1:0] IRQ_MASK = (NFLAG'(1) << F_WIN) |
                                          (NFLAG'(1) << F_WER) |
                                          (NFLAG'(1) << F_TMO);
endpackage

// File: rtl/fws_rst_sync.sv
module fws_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/fws_wr_check.sv
module fws_wr_check #(
  parameter int DW = 32
) (
  input  logic          wr_prot,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] wr_old,
  output logic          wr_bad
);
  logic [DW-1:0] up_bit;

  // A bit that asks for 1 over a stored 0 cannot be programmed.
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign up_bit[i] = wr_data[i] & ~wr_old[i];
  end

  assign wr_bad = wr_prot | (|up_bit);
endmodule

// File: rtl/fws_flag.sv
module fws_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic srst_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = srst_i | set_i | clr_i;
    if (srst_i)     q_d = 1'b0;
    else if (set_i) q_d = 1'b1;
    else            q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/fws_status.sv
module fws_status
  import fws_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            seq_en,
  input  logic            seq_idle,
  input  logic [STW-1:0]  seq_state,
  input  logic            cpu_acc,
  input  logic            wr_req,
  input  logic            wr_prot,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW-1:0]   wr_old,
  input  logic            eng_err,
  input  logic            eng_tmo,
  input  logic            eng_done,
  input  logic            reg_wr,
  input  logic [RW-1:0]   reg_wdata,
  input  logic            reg_rmw,
  input  logic            soft_rst,
  input  logic            err_irq_en,
  output logic [RW-1:0]   reg_rdata,
  output logic            err_irq
);
  logic             rst_ni;
  logic             en_q;
  logic             en_d;
  logic             wr_bad;
  logic [NFLAG-1:0] set_vec;
  logic [NFLAG-1:0] clr_vec;
  logic [NFLAG-1:0] flags;

  fws_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_ni)
  );

  fws_wr_check #(.DW(DW)) u_chk_wr (
    .wr_prot (wr_prot),
    .wr_data (wr_data),
    .wr_old  (wr_old),
    .wr_bad  (wr_bad)
  );

  // Enable history, used to see the disabling edge.
  always_comb en_d = seq_en;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  always_comb begin
    set_vec        = '0;
    set_vec[F_PAC] = seq_en & cpu_acc & ~seq_idle;
    set_vec[F_WIN] = en_q & ~seq_en & ~seq_idle;
    set_vec[F_WER] = seq_en & ((wr_req & wr_bad) | eng_err);
    set_vec[F_TMO] = seq_en & eng_tmo;
    set_vec[F_FIN] = seq_en & eng_done;
    clr_vec        = {NFLAG{reg_wr}} & ~reg_wdata[RW-1 -: NFLAG];
  end

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    fws_flag u_flag (
      .clk    (clk),
      .rst_ni (rst_ni),
      .set_i  (set_vec[f]),
      .clr_i  (clr_vec[f]),
      .srst_i (soft_rst),
      .q_o    (flags[f])
    );
  end

  always_comb begin
    reg_rdata = {(reg_rmw ? {NFLAG{1'b1}} : flags), seq_idle, seq_state};
    err_irq   = err_irq_en & (|(flags & IRQ_MASK));
  end
endmodule

// File: rtl/fws_status_chk.sv
module fws_status_chk
  import fws_pkg::*;
#(
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             seq_en,
  input logic             soft_rst,
  input logic             wr_req,
  input logic             wr_prot,
  input logic [DW-1:0]    wr_data,
  input logic [DW-1:0]    wr_old,
  input logic             reg_rmw,
  input logic [RW-1:0]    reg_rdata,
  input logic             err_irq_en,
  input logic             err_irq,
  input logic [NFLAG-1:0] flags
);
  localparam logic [NFLAG-1:0] NO_WIN = ~(NFLAG'(1) << F_WIN);

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_ni)
    (!seq_en && !soft_rst) |=> ((flags & ~$past(flags) & NO_WIN) == '0)); // R7

  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    soft_rst |=> (flags == '0)); // R9

  AST_RMW_READS_ONES: assert property (@(posedge clk) disable iff (!rst_ni)
    reg_rmw |-> (reg_rdata[RW-1 -: NFLAG] == '1)); // R10

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !err_irq_en |-> !err_irq); // R11

  AST_ILLEGAL_BIT_ERR: assert property (@(posedge clk) disable iff (!rst_ni)
    (seq_en && wr_req && (|(wr_data & ~wr_old)) && !soft_rst) |=> flags[F_WER]); // R5

  AST_PROT_ERR: assert property (@(posedge clk) disable iff (!rst_ni)
    (seq_en && wr_req && wr_prot && !soft_rst) |=> flags[F_WER]); // R4
endmodule

bind fws_status fws_status_chk #(.DW(DW)) u_status_chk (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .seq_en     (seq_en),
  .soft_rst   (soft_rst),
  .wr_req     (wr_req),
  .wr_prot    (wr_prot),
  .wr_data    (wr_data),
  .wr_old     (wr_old),
  .reg_rmw    (reg_rmw),
  .reg_rdata  (reg_rdata),
  .err_irq_en (err_irq_en),
  .err_irq    (err_irq),
  .flags      (flags)
);

// File: tb/test_fws_status.sv
module test_fws_status;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          seq_en, seq_idle, cpu_acc, wr_req, wr_prot;
  logic [1:0]    seq_state;
  logic [DW-1:0] wr_data, wr_old;
  logic          eng_err, eng_tmo, eng_done;
  logic          reg_wr, reg_rmw, soft_rst, err_irq_en;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic          err_irq;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  // Reference state: flags in byte order {pa, wi, we, to, fin}.
  bit  m_pa, m_wi, m_we, m_to, m_fin, m_en;

  always #5 clk = ~clk;

  fws_status #(.DW(DW)) i_fws_status (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .seq_idle(seq_idle),
    .seq_state(seq_state), .cpu_acc(cpu_acc), .wr_req(wr_req),
    .wr_prot(wr_prot), .wr_data(wr_data), .wr_old(wr_old),
    .eng_err(eng_err), .eng_tmo(eng_tmo), .eng_done(eng_done),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rmw(reg_rmw),
    .soft_rst(soft_rst), .err_irq_en(err_irq_en),
    .reg_rdata(reg_rdata), .err_irq(err_irq)
  );

  task automatic check(string tag, logic [7:0] got_d, logic [7:0] exp_d,
                       logic got_i, logic exp_i);
    n_chk++;
    if (got_d !== exp_d) begin
      n_fail++;
      $display("FAIL %s reg_rdata actual=%02h expected=%02h", tag, got_d, exp_d);
    end
    n_chk++;
    if (got_i !== exp_i) begin
      n_fail++;
      $display("FAIL %s err_irq actual=%0b expected=%0b", tag, got_i, exp_i);
    end
  endtask

  task automatic model_edge();
    bit set_pa, set_wi, set_we, set_to, set_fin;
    set_pa  = seq_en && cpu_acc && !seq_idle;
    set_wi  = m_en && !seq_en && !seq_idle;
    set_we  = seq_en && (eng_err || (wr_req && (wr_prot || ((wr_data & ~wr_old) != 0))));
    set_to  = seq_en && eng_tmo;
    set_fin = seq_en && eng_done;
    if (soft_rst) begin
      {m_pa, m_wi, m_we, m_to, m_fin} = '0;
    end else begin
      if (set_pa) m_pa = 1; else if (reg_wr && !reg_wdata[7]) m_pa = 0;
      if (set_wi) m_wi = 1; else if (reg_wr && !reg_wdata[6]) m_wi = 0;
      if (set_we) m_we = 1; else if (reg_wr && !reg_wdata[5]) m_we = 0;
      if (set_to) m_to = 1; else if (reg_wr && !reg_wdata[4]) m_to = 0;
      if (set_fin) m_fin = 1; else if (reg_wr && !reg_wdata[3]) m_fin = 0;
    end
    m_en = seq_en;
  endtask

  // One clock: inputs already applied; update model at the edge, compare at
  // the following falling edge, then drop all one-cycle strobes.
  task automatic step(string tag);
    logic [7:0] exp_d;
    logic       exp_i;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    exp_d = reg_rmw ? {5'b11111, seq_idle, seq_state}
                    : {m_pa, m_wi, m_we, m_to, m_fin, seq_idle, seq_state};
    exp_i = err_irq_en && (m_wi || m_we || m_to);
    check(tag, reg_rdata, exp_d, err_irq, exp_i);
    cpu_acc = 0; wr_req = 0; wr_prot = 0; eng_err = 0; eng_tmo = 0;
    eng_done = 0; reg_wr = 0; reg_wdata = 8'hFF; soft_rst = 0; reg_rmw = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; seq_en = 0; seq_idle = 0; seq_state = 0; cpu_acc = 0;
    wr_req = 0; wr_prot = 0; wr_data = 0; wr_old = 0; eng_err = 0;
    eng_tmo = 0; eng_done = 0; reg_wr = 0; reg_wdata = 8'hFF;
    reg_rmw = 0; soft_rst = 0; err_irq_en = 0;
    {m_pa, m_wi, m_we, m_to, m_fin, m_en} = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", reg_rdata, 8'h00, err_irq, 1'b0);
    rst_n = 1;
    repeat (3) step("R1 after reset");

    // R7: everything fires while disabled
    seq_idle = 0; cpu_acc = 1; wr_req = 1; wr_prot = 1; wr_data = 32'hF;
    wr_old = 0; eng_err = 1; eng_tmo = 1; eng_done = 1; err_irq_en = 1;
    step("R7 disabled events");
    step("R7 disabled hold");

    // R2: prohibited access
    seq_en = 1; seq_idle = 1; step("R2 enable");
    cpu_acc = 1; step("R2 access while idle");
    seq_idle = 0; cpu_acc = 1; step("R2 access while busy");
    step("R11 pa gives no irq");

    // R8: clear by writing 0, writing 1 no effect
    reg_wr = 1; reg_wdata = 8'hFF; step("R8 write ones");
    reg_wr = 1; reg_wdata = 8'h7F; step("R8 clear pa");

    // R5: illegal bit transition, legal write
    wr_req = 1; wr_data = 32'h0000_000F; wr_old = 32'hFFFF_FFFF;
    step("R5 legal write");
    wr_req = 1; wr_data = 32'h8000_0000; wr_old = 32'h7FFF_FFFF;
    step("R5 stored zero to one");
    step("R11 we gives irq");
    err_irq_en = 0; step("R11 irq disabled");
    err_irq_en = 1;
    reg_wr = 1; reg_wdata = 8'hDF; step("R8 clear we");

    // R4: protected sector
    wr_req = 1; wr_prot = 1; wr_data = 0; wr_old = 32'hFFFF_FFFF;
    step("R4 protected sector");
    reg_wr = 1; reg_wdata = 8'h00; step("R8 clear all");

    // R6: engine pulses
    eng_tmo = 1; step("R6 timeout");
    eng_done = 1; step("R6 done");
    eng_err = 1; step("R6 engine error");

    // R10: read-modify-write read
    reg_rmw = 1; seq_state = 2'b01; step("R10 rmw read");
    reg_rmw = 1; reg_wr = 1; reg_wdata = 8'hFF; step("R10 rmw writeback keeps");

    // R8: set wins over same-cycle clear
    reg_wr = 1; reg_wdata = 8'h00; eng_tmo = 1; step("R8 set beats clear");

    // R9: soft reset wins over set
    soft_rst = 1; eng_err = 1; cpu_acc = 1; step("R9 soft reset");
    step("R9 after soft reset");

    // R3: disable while busy vs idle
    seq_idle = 0; seq_en = 0; step("R3 disable while busy");
    step("R3 held");
    reg_wr = 1; reg_wdata = 8'hBF; step("R8 clear wi");
    seq_en = 1; seq_idle = 1; step("R3 re-enable");
    seq_en = 0; step("R3 disable while idle");

    // R12: layout of live fields
    seq_en = 1; seq_idle = 1; seq_state = 2'b10; eng_done = 1;
    step("R12 layout fin idle state");
    seq_idle = 0; seq_state = 2'b11; cpu_acc = 1; step("R12 layout pa");
    step("R12 settle");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule